// File: doc/BRIEF.md
# Interrupt Request Flag Bank

This block holds one request flag per interrupt source of a small microcontroller, together with a per-source enable register and a single master enable. A one-cycle event pulse from a peripheral sets the matching flag no matter how the enables stand. The block drives a vector of pending requests to the CPU and drops a flag again when the CPU reports that it has taken that source.

Software reaches the flags, the enables and the master enable through a simple register bus with byte and word access. Writing a one to a flag raises a software interrupt. Such a flag is held back from the pending vector until the CPU signals that one more instruction has retired. Each flag is a three-state machine. `FS_IDLE` means clear. `FS_LIVE` means set and eligible. `FS_SOFT` means set by software and waiting for a retire.

The flag machine has these transitions:
- `FS_IDLE` to `FS_LIVE` on an event.
- `FS_IDLE` to `FS_SOFT` on a software write of 1.
- `FS_SOFT` to `FS_LIVE` on an event or on a retire strobe.
- `FS_LIVE` or `FS_SOFT` to `FS_IDLE` on a software write of 0 or on an acknowledge.

An event in the same cycle always takes precedence over a clear. When a software write and an acknowledge hit the same bit in the same cycle, the write decides the outcome.

Top module: `irq_flag_bank`

## Requirements
- R1: An event pulse on an implemented source sets its flag at the next clock edge, whatever the enable bit and the master enable hold.
- R2: `irq_pend` bit i is 1 only when flag i is set and eligible, enable i is 1 and the master enable is 1. When the master enable is 0, `irq_pend` is all zero.
- R3: A bus write of 1 to a flag sets it. That flag stays out of `irq_pend` until a `retire_stb` arrives in a cycle after the write cycle. A retire in the write cycle itself does not count.
- R4: `ack_stb` with bit i of `ack_onehot` clears flag i at the next edge.
- R5: Bits 9, 7, 5 and 3 are reserved. Flags and enables at these bits read 0, and bus writes and events at these bits have no effect.
- R6: After reset, flags, enables, the master enable and `irq_pend` are all zero.
- R7: The register map uses these byte addresses:
  - 0 holds the flag low byte and 1 the flag high byte.
  - 2 holds the enable low byte and 3 the enable high byte.
  - 4 holds the master enable in bit 0.
  - A word access (`bus_word`=1) ignores address bit 0. A byte write takes its data from `bus_wdata[7:0]`. A byte read returns the byte in `bus_rdata[7:0]` with the upper byte zero.
- R8: A bus write of 0 clears a flag. An event in the same cycle as that write leaves the flag set.
- R9: An event in the same cycle as an acknowledge of the same source leaves the flag set.
- R10: An event on a flag that software set and that is still waiting for a retire makes it eligible at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_pulse | input | 16 | One-cycle event pulses, one per source |
| ack_stb | input | 1 | CPU acknowledge strobe |
| ack_onehot | input | 16 | One-hot index of the acknowledged source |
| retire_stb | input | 1 | One instruction retired |
| bus_addr | input | 3 | Register byte address |
| bus_wen | input | 1 | Write strobe |
| bus_word | input | 1 | 1 selects a 16-bit access, 0 an 8-bit access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| irq_pend | output | 16 | Masked pending requests to the CPU |

## Verification
The hardest situations to reach from the ports are collisions inside a single cycle. These are an event landing together with a software clear or with an acknowledge, and a retire strobe landing in the very cycle of the software write it must not release. The bench drives the bus, the event lines, the acknowledge and the retire strobe from one task in the same clock cycle, so these races happen exactly on one edge. It then reads the flags back over the bus and watches `irq_pend` to see which action won.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_LIVE = 2'd1,
        FS_SOFT = 2'd2
    } flag_state_e;

    localparam logic [1:0] SEL_FLAG = 2'd0;
    localparam logic [1:0] SEL_ENAB = 2'd1;
    localparam logic [1:0] SEL_MAST = 2'd2;
endpackage

// File: rtl/irqf_flag_fsm.sv
module irqf_flag_fsm
    import irqf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_i,
    input  logic ack_i,
    input  logic wr_i,
    input  logic wd_i,
    input  logic retire_i,
    output logic flag_o,
    output logic elig_o
);
    flag_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FS_IDLE: begin
                if (ev_i)              st_d = FS_LIVE;
                else if (wr_i && wd_i) st_d = FS_SOFT;
            end
            FS_LIVE: begin
                if (ev_i)              st_d = FS_LIVE;
                else if (wr_i)         st_d = wd_i ? FS_LIVE : FS_IDLE;
                else if (ack_i)        st_d = FS_IDLE;
            end
            FS_SOFT: begin
                if (ev_i)              st_d = FS_LIVE;
                else if (wr_i)         st_d = wd_i ? FS_SOFT : FS_IDLE;
                else if (ack_i)        st_d = FS_IDLE;
                else if (retire_i)     st_d = FS_LIVE;
            end
            default:                   st_d = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FS_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        flag_o = (st_q != FS_IDLE);
        elig_o = (st_q == FS_LIVE);
    end
endmodule

// File: rtl/irqf_bus_decode.sv
module irqf_bus_decode
    import irqf_pkg::*;
#(
    parameter int unsigned WIDTH = 16,
    localparam int unsigned LANES = WIDTH / 8,
    localparam int unsigned LB = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int unsigned AW = LB + 2
) (
    input  logic [AW-1:0]    addr_i,
    input  logic             wen_i,
    input  logic             word_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [WIDTH-1:0] flag_i,
    input  logic [WIDTH-1:0] enab_i,
    input  logic             mie_i,
    output logic [WIDTH-1:0] wr_flag_o,
    output logic [WIDTH-1:0] wr_enab_o,
    output logic             wr_mie_o,
    output logic [WIDTH-1:0] wlane_o,
    output logic [WIDTH-1:0] rdata_o
);
    logic [1:0]       sel;
    logic [LB-1:0]    lane_idx;
    logic [WIDTH-1:0] bit_mask;
    logic [WIDTH-1:0] rsrc;

    assign sel      = addr_i[AW-1:LB];
    assign lane_idx = addr_i[LB-1:0];
    assign wlane_o  = word_i ? wdata_i : {LANES{wdata_i[7:0]}};

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign bit_mask[8*l +: 8] = {8{word_i || (lane_idx == LB'(l))}};
    end

    always_comb begin
        wr_flag_o = '0;
        wr_enab_o = '0;
        wr_mie_o  = 1'b0;
        if (wen_i) begin
            unique case (sel)
                SEL_FLAG: wr_flag_o = bit_mask;
                SEL_ENAB: wr_enab_o = bit_mask;
                SEL_MAST: wr_mie_o  = word_i || (lane_idx == '0);
                default:  ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            SEL_FLAG: rsrc = flag_i;
            SEL_ENAB: rsrc = enab_i;
            SEL_MAST: rsrc = {{(WIDTH-1){1'b0}}, mie_i};
            default:  rsrc = '0;
        endcase
        if (word_i) rdata_o = rsrc;
        else        rdata_o = {{(WIDTH-8){1'b0}}, rsrc[8*lane_idx +: 8]};
    end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int unsigned WIDTH = 16,
    parameter logic [WIDTH-1:0] IMPL_MASK = 16'hFD57,
    localparam int unsigned LANES = WIDTH / 8,
    localparam int unsigned LB = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int unsigned AW = LB + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] ev_pulse,
    input  logic             ack_stb,
    input  logic [WIDTH-1:0] ack_onehot,
    input  logic             retire_stb,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wen,
    input  logic             bus_word,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    output logic [WIDTH-1:0] irq_pend
);
    logic [WIDTH-1:0] flag_vec;
    logic [WIDTH-1:0] elig_vec;
    logic [WIDTH-1:0] en_q;
    logic             mie_q;
    logic [WIDTH-1:0] wr_flag;
    logic [WIDTH-1:0] wr_enab;
    logic             wr_mie;
    logic [WIDTH-1:0] wlane;

    irqf_bus_decode #(.WIDTH(WIDTH)) u_dec (
        .addr_i    (bus_addr),
        .wen_i     (bus_wen),
        .word_i    (bus_word),
        .wdata_i   (bus_wdata),
        .flag_i    (flag_vec),
        .enab_i    (en_q),
        .mie_i     (mie_q),
        .wr_flag_o (wr_flag),
        .wr_enab_o (wr_enab),
        .wr_mie_o  (wr_mie),
        .wlane_o   (wlane),
        .rdata_o   (bus_rdata)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_src
        if (IMPL_MASK[i]) begin : g_impl
            irqf_flag_fsm u_fsm (
                .clk      (clk),
                .rst_n    (rst_n),
                .ev_i     (ev_pulse[i]),
                .ack_i    (ack_stb && ack_onehot[i]),
                .wr_i     (wr_flag[i]),
                .wd_i     (wlane[i]),
                .retire_i (retire_stb),
                .flag_o   (flag_vec[i]),
                .elig_o   (elig_vec[i])
            );
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)          en_q[i] <= 1'b0;
                else if (wr_enab[i]) en_q[i] <= wlane[i];
            end
        end else begin : g_rsvd
            assign flag_vec[i] = 1'b0;
            assign elig_vec[i] = 1'b0;
            assign en_q[i]     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      mie_q <= 1'b0;
        else if (wr_mie) mie_q <= wlane[0];
    end

    assign irq_pend = elig_vec & en_q & {WIDTH{mie_q}};
endmodule

// File: rtl/irqf_checker.sv
module irqf_checker #(
    parameter int unsigned WIDTH = 16,
    parameter logic [WIDTH-1:0] IMPL_MASK = 16'hFD57
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] ev_pulse,
    input logic             ack_stb,
    input logic [WIDTH-1:0] ack_onehot,
    input logic [WIDTH-1:0] flag_vec,
    input logic [WIDTH-1:0] en_q,
    input logic             mie_q,
    input logic [WIDTH-1:0] wr_flag,
    input logic [WIDTH-1:0] irq_pend
);
    AST_EVENT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        |(ev_pulse & IMPL_MASK) |=> ((flag_vec & $past(ev_pulse & IMPL_MASK)) == $past(ev_pulse & IMPL_MASK))); // R1

    AST_PEND_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        !mie_q |-> (irq_pend == '0)); // R2

    AST_PEND_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend & ~(flag_vec & en_q)) == '0); // R2

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_stb && ((ack_onehot & (ev_pulse | wr_flag)) == '0))
        |=> ((flag_vec & $past(ack_onehot)) == '0)); // R4

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_vec | en_q) & ~IMPL_MASK) == '0); // R5
endmodule

bind irq_flag_bank irqf_checker #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_pulse   (ev_pulse),
    .ack_stb    (ack_stb),
    .ack_onehot (ack_onehot),
    .flag_vec   (flag_vec),
    .en_q       (en_q),
    .mie_q      (mie_q),
    .wr_flag    (wr_flag),
    .irq_pend   (irq_pend)
);

// File: tb/test_irq_flag_bank.sv
module test_irq_flag_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ev_pulse = '0;
    logic        ack_stb = 1'b0;
    logic [15:0] ack_onehot = '0;
    logic        retire_stb = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic        bus_word = 1'b1;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] irq_pend;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irq_flag_bank i_irq_flag_bank (
        .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .ack_stb(ack_stb),
        .ack_onehot(ack_onehot), .retire_stb(retire_stb), .bus_addr(bus_addr),
        .bus_wen(bus_wen), .bus_word(bus_word), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_pend(irq_pend)
    );

    // wen, waddr, wword, wdata, raddr, rword, expected read
    localparam int NV = 10;
    localparam logic [40:0] VEC [NV] = '{
        {1'b1, 3'd0, 1'b1, 16'hFFFF, 3'd0, 1'b1, 16'hFD57},
        {1'b1, 3'd1, 1'b0, 16'h0000, 3'd0, 1'b1, 16'h0057},
        {1'b1, 3'd0, 1'b0, 16'h0000, 3'd0, 1'b0, 16'h0000},
        {1'b1, 3'd2, 1'b0, 16'h00FF, 3'd2, 1'b1, 16'h0057},
        {1'b1, 3'd3, 1'b0, 16'h00FF, 3'd3, 1'b0, 16'h00FD},
        {1'b1, 3'd2, 1'b1, 16'h0000, 3'd2, 1'b1, 16'h0000},
        {1'b1, 3'd4, 1'b0, 16'h0001, 3'd4, 1'b1, 16'h0001},
        {1'b1, 3'd4, 1'b1, 16'h0000, 3'd4, 1'b0, 16'h0000},
        {1'b1, 3'd3, 1'b1, 16'h1234, 3'd2, 1'b1, 16'h1014},
        {1'b1, 3'd2, 1'b1, 16'h0000, 3'd2, 1'b1, 16'h0000}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle of stimulus, applied at a falling edge and removed at the next.
    task automatic cyc(input logic [15:0] ev, input logic ack, input logic [15:0] aoh,
                       input logic ret, input logic wen, input logic [2:0] a,
                       input logic wd, input logic [15:0] d);
        @(negedge clk);
        ev_pulse = ev; ack_stb = ack; ack_onehot = aoh; retire_stb = ret;
        bus_wen = wen; bus_addr = a; bus_word = wd; bus_wdata = d;
        @(negedge clk);
        ev_pulse = '0; ack_stb = 1'b0; ack_onehot = '0; retire_stb = 1'b0; bus_wen = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic wd, input logic [15:0] d);
        cyc('0, 1'b0, '0, 1'b0, 1'b1, a, wd, d);
    endtask

    task automatic rd(input string tag, input logic [2:0] a, input logic wd, input logic [15:0] exp);
        bus_addr = a; bus_word = wd;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6 reset state
        rd("R6 flags", 3'd0, 1'b1, 16'h0000);
        rd("R6 enables", 3'd2, 1'b1, 16'h0000);
        rd("R6 master", 3'd4, 1'b1, 16'h0000);
        chk("R6 pend", irq_pend, 16'h0000);

        // R7 R5 R3 R8 register access table
        for (int k = 0; k < NV; k++) begin
            if (VEC[k][40]) wr(VEC[k][39:37], VEC[k][36], VEC[k][35:20]);
            rd($sformatf("R7 table row %0d", k), VEC[k][19:17], VEC[k][16], VEC[k][15:0]);
        end

        // R1 event latches with enables off
        cyc(16'h8000, 1'b0, '0, 1'b0, 1'b0, 3'd0, 1'b1, '0);
        rd("R1 event latch", 3'd0, 1'b1, 16'h8000);
        chk("R2 pend no enable", irq_pend, 16'h0000);
        wr(3'd2, 1'b1, 16'hC000);
        chk("R2 pend master off", irq_pend, 16'h0000);
        wr(3'd4, 1'b1, 16'h0001);
        chk("R2 pend all set", irq_pend, 16'h8000);

        // R4 acknowledge clears
        cyc('0, 1'b1, 16'h8000, 1'b0, 1'b0, 3'd0, 1'b1, '0);
        rd("R4 ack clear", 3'd0, 1'b1, 16'h0000);
        chk("R4 pend after ack", irq_pend, 16'h0000);

        // R3 software set, retire in the write cycle does not release it
        cyc('0, 1'b0, '0, 1'b1, 1'b1, 3'd0, 1'b1, 16'h4000);
        rd("R3 soft flag", 3'd0, 1'b1, 16'h4000);
        chk("R3 held back", irq_pend, 16'h0000);
        cyc('0, 1'b0, '0, 1'b1, 1'b0, 3'd0, 1'b1, '0);
        chk("R3 released by retire", irq_pend, 16'h4000);
        cyc('0, 1'b1, 16'h4000, 1'b0, 1'b0, 3'd0, 1'b1, '0);

        // R10 event releases a software-held flag
        wr(3'd0, 1'b1, 16'h4000);
        chk("R10 held", irq_pend, 16'h0000);
        cyc(16'h4000, 1'b0, '0, 1'b0, 1'b0, 3'd0, 1'b1, '0);
        chk("R10 event release", irq_pend, 16'h4000);
        cyc('0, 1'b1, 16'h4000, 1'b0, 1'b0, 3'd0, 1'b1, '0);

        // R8 event beats software clear
        wr(3'd0, 1'b1, 16'h2000);
        cyc(16'h2000, 1'b0, '0, 1'b0, 1'b1, 3'd0, 1'b1, 16'h0000);
        rd("R8 event beats clear", 3'd0, 1'b1, 16'h2000);
        wr(3'd0, 1'b1, 16'h0000);
        rd("R8 write zero clears", 3'd0, 1'b1, 16'h0000);

        // R9 event beats acknowledge
        cyc(16'h0100, 1'b0, '0, 1'b0, 1'b0, 3'd0, 1'b1, '0);
        cyc(16'h0100, 1'b1, 16'h0100, 1'b0, 1'b0, 3'd0, 1'b1, '0);
        rd("R9 event beats ack", 3'd0, 1'b1, 16'h0100);
        cyc('0, 1'b1, 16'h0100, 1'b0, 1'b0, 3'd0, 1'b1, '0);
        rd("R9 later ack clears", 3'd0, 1'b1, 16'h0000);

        // R5 events on reserved bits
        cyc(16'h02A8, 1'b0, '0, 1'b0, 1'b0, 3'd0, 1'b1, '0);
        rd("R5 reserved events", 3'd0, 1'b1, 16'h0000);

        // R2 masking across all sources
        cyc(16'hFFFF, 1'b0, '0, 1'b0, 1'b0, 3'd0, 1'b1, '0);
        rd("R1 all events", 3'd0, 1'b1, 16'hFD57);
        chk("R2 masked by enables", irq_pend, 16'hC000);
        wr(3'd4, 1'b0, 16'h0000);
        chk("R2 master off", irq_pend, 16'h0000);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule